// File: doc/BRIEF.md
# Single-Master Bus Interconnect with Decode Error Capture

This block joins one bus master to three slaves: a register bank, a capture scope and a block memory. The master issues word-addressed requests. A byte address is the word address shifted left by two. The block decodes the word address into one select line per slave. It passes the master strobe to a slave only when that slave is selected. The cycle, write-enable, address, write-data and byte-lane lines go to every slave unchanged.

On the return path, the stall seen by the master is taken combinationally from the selected slave. The acknowledge and read data are both registered, so they stay aligned. When several slaves acknowledge at once, the read data follows a fixed priority. A strobed access that matches no slave produces a one-clock error pulse, and the block records the address that is on the bus while that pulse is high. The two slave interrupt lines are merged into one.

The error path is a two-state machine. It has a quiet state (ERR_QUIET) and a pulse state (ERR_PULSE). It enters ERR_PULSE after any clock whose strobe is high with no slave selected, and it returns to ERR_QUIET after any other clock. Reset forces ERR_QUIET.

Top module: `wbx_interconnect`

## Requirements
- R1: The register slave (strobe bit 0) is strobed exactly when the master strobe is high and word-address bits [29:4] equal 0x081 (byte address 0x2040).
- R2: The scope slave (strobe bit 1) is strobed exactly when the master strobe is high and word-address bits [29:4] equal 0x082 (byte address 0x2080).
- R3: The memory slave (strobe bit 2) is strobed exactly when the master strobe is high and word-address bits [29:12] equal 1 (byte address 0x4000).
- R4: Any other address, including word address 0, strobes no slave. At most one slave strobe is ever high.
- R5: `m_err` is high in the clock after each cycle in which `m_stb` is high and no slave is selected. It is low after every other cycle.
- R6: On every clock edge where `m_err` is high, `err_addr` loads the word address present on `m_adr`. Otherwise `err_addr` holds its value.
- R7: `m_stall` is combinational. It equals the stall bit of the slave that the current address selects, and it is 0 when no slave is selected.
- R8: `m_ack` is high exactly one clock after any cycle in which at least one slave acknowledge is high.
- R9: `m_dat_r` is registered and loads, one clock later, the read data of the highest-priority acknowledging slave. The priority order is register slave, then scope, then memory. When no slave acknowledges, it loads zero.
- R10: `irq` is the combinational OR of `reg_irq` and `scope_irq`.
- R11: `s_cyc`, `s_we`, `s_adr`, `s_dat_w` and `s_sel` equal the corresponding master inputs in the same cycle.
- R12: While `rst_n` is low, the next edge clears `m_ack`, `m_err`, `m_dat_r` and `err_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | 30 | Master word address |
| m_dat_w | input | 32 | Master write data |
| m_sel | input | 4 | Master byte lanes |
| m_stall | output | 1 | Stall to master |
| m_ack | output | 1 | Registered acknowledge to master |
| m_err | output | 1 | Registered one-clock decode error |
| m_dat_r | output | 32 | Registered read data to master |
| err_addr | output | 30 | Captured word address of the last error |
| irq | output | 1 | Merged interrupt |
| s_cyc | output | 1 | Cycle to all slaves |
| s_stb | output | 3 | Per-slave gated strobe (0 reg, 1 scope, 2 mem) |
| s_we | output | 1 | Write enable to all slaves |
| s_adr | output | 30 | Word address to all slaves |
| s_dat_w | output | 32 | Write data to all slaves |
| s_sel | output | 4 | Byte lanes to all slaves |
| s_stall | input | 3 | Per-slave stall |
| s_ack | input | 3 | Per-slave acknowledge |
| s_dat_r | input | 96 | Per-slave read data, slave i at bits [32i+31:32i] |
| reg_irq | input | 1 | Register slave interrupt |
| scope_irq | input | 1 | Scope interrupt |

## Verification
Directed addresses probe the decode edges: the first and last word of each window, the words just outside each window, and word zero. These separate a correct compare from one with the wrong bit range or the wrong match value. Acknowledge patterns with two or three slaves active at once separate the correct priority order from a swapped one, and an all-idle acknowledge pattern shows the zero fill. Random traffic biased toward the three windows mixes back-to-back bad accesses, stalls and interrupts. It catches errors that stretch or vanish, a capture taken from the wrong cycle, and a stall taken from a slave that is not selected.

// File: rtl/wbx_pkg.sv
package wbx_pkg;
    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;
    localparam int SEL_W  = DATA_W / 8;
    localparam int NSLV   = 3;

    localparam int SLV_REG   = 0;
    localparam int SLV_SCOPE = 1;
    localparam int SLV_MEM   = 2;

    typedef enum logic {
        ERR_QUIET = 1'b0,
        ERR_PULSE = 1'b1
    } err_state_t;

    // lowest address bit compared for a slave window
    function automatic int slv_lsb(input int idx);
        case (idx)
            SLV_REG:   return 4;
            SLV_SCOPE: return 4;
            default:   return 12;
        endcase
    endfunction

    // value the shifted address must equal for a slave window
    function automatic logic [ADDR_W-1:0] slv_match(input int idx);
        case (idx)
            SLV_REG:   return ADDR_W'(32'h081);
            SLV_SCOPE: return ADDR_W'(32'h082);
            default:   return ADDR_W'(32'h001);
        endcase
    endfunction
endpackage

// File: rtl/wbx_addr_decode.sv
module wbx_addr_decode
    import wbx_pkg::*;
#(
    parameter int              LSB   = 4,
    parameter logic [ADDR_W-1:0] MATCH = '0
) (
    input  logic [ADDR_W-1:0] adr,
    output logic              hit
);
    always_comb begin
        hit = ((adr >> LSB) == MATCH);
    end
endmodule

// File: rtl/wbx_resp_merge.sv
module wbx_resp_merge
    import wbx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLV-1:0]        sel,
    input  logic [NSLV-1:0]        s_stall,
    input  logic [NSLV-1:0]        s_ack,
    input  logic [NSLV*DATA_W-1:0] s_dat_r,
    output logic                   m_stall,
    output logic                   m_ack,
    output logic [DATA_W-1:0]      m_dat_r
);
    logic [DATA_W-1:0] dat_nxt;

    always_comb begin
        m_stall = |(sel & s_stall);
    end

    // lowest index is visited last, so it wins
    always_comb begin
        dat_nxt = '0;
        for (int i = NSLV - 1; i >= 0; i--) begin
            if (s_ack[i]) begin
                dat_nxt = s_dat_r[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_ack   <= 1'b0;
            m_dat_r <= '0;
        end else begin
            m_ack   <= |s_ack;
            m_dat_r <= dat_nxt;
        end
    end
endmodule

// File: rtl/wbx_err_track.sv
module wbx_err_track
    import wbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              none_sel,
    input  logic [ADDR_W-1:0] adr,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr
);
    err_state_t state_q, state_d;

    always_comb begin
        state_d = ERR_QUIET;
        unique case (state_q)
            ERR_QUIET: state_d = (stb && none_sel) ? ERR_PULSE : ERR_QUIET;
            ERR_PULSE: state_d = (stb && none_sel) ? ERR_PULSE : ERR_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ERR_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        err = (state_q == ERR_PULSE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr <= '0;
        end else if (err) begin
            err_addr <= adr;
        end
    end
endmodule

// File: rtl/wbx_interconnect.sv
module wbx_interconnect
    import wbx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   m_cyc,
    input  logic                   m_stb,
    input  logic                   m_we,
    input  logic [ADDR_W-1:0]      m_adr,
    input  logic [DATA_W-1:0]      m_dat_w,
    input  logic [SEL_W-1:0]       m_sel,
    output logic                   m_stall,
    output logic                   m_ack,
    output logic                   m_err,
    output logic [DATA_W-1:0]      m_dat_r,
    output logic [ADDR_W-1:0]      err_addr,
    output logic                   irq,
    output logic                   s_cyc,
    output logic [NSLV-1:0]        s_stb,
    output logic                   s_we,
    output logic [ADDR_W-1:0]      s_adr,
    output logic [DATA_W-1:0]      s_dat_w,
    output logic [SEL_W-1:0]       s_sel,
    input  logic [NSLV-1:0]        s_stall,
    input  logic [NSLV-1:0]        s_ack,
    input  logic [NSLV*DATA_W-1:0] s_dat_r,
    input  logic                   reg_irq,
    input  logic                   scope_irq
);
    logic [NSLV-1:0] sel;
    logic            none_sel;

    for (genvar g = 0; g < NSLV; g++) begin : g_dec
        wbx_addr_decode #(
            .LSB   (slv_lsb(g)),
            .MATCH (slv_match(g))
        ) u_dec (
            .adr (m_adr),
            .hit (sel[g])
        );
    end

    always_comb begin
        none_sel = ~|sel;
        s_stb    = sel & {NSLV{m_stb}};
        s_cyc    = m_cyc;
        s_we     = m_we;
        s_adr    = m_adr;
        s_dat_w  = m_dat_w;
        s_sel    = m_sel;
        irq      = reg_irq | scope_irq;
    end

    wbx_resp_merge u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .s_stall (s_stall),
        .s_ack   (s_ack),
        .s_dat_r (s_dat_r),
        .m_stall (m_stall),
        .m_ack   (m_ack),
        .m_dat_r (m_dat_r)
    );

    wbx_err_track u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (m_stb),
        .none_sel (none_sel),
        .adr      (m_adr),
        .err      (m_err),
        .err_addr (err_addr)
    );
endmodule

// File: rtl/wbx_interconnect_chk.sv
module wbx_interconnect_chk
    import wbx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              m_stb,
    input logic [ADDR_W-1:0] m_adr,
    input logic [NSLV-1:0]   s_stb,
    input logic [NSLV-1:0]   s_ack,
    input logic              m_stall,
    input logic              m_ack,
    input logic              m_err,
    input logic [DATA_W-1:0] m_dat_r,
    input logic [ADDR_W-1:0] err_addr
);
    assert_one_slave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_stb));

    assert_no_stb_leak_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !m_stb |-> (s_stb == '0));

    assert_err_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stb && s_stb == '0) |=> m_err);

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_stb && s_stb == '0) |=> !m_err);

    assert_err_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |=> (err_addr == $past(m_adr)));

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !m_err |=> $stable(err_addr));

    assert_ack_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_ack) |=> m_ack);

    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|s_ack) |=> !m_ack);

    assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|s_ack) |=> (m_dat_r == '0));

    assert_unmatched_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stb && s_stb == '0) |-> !m_stall);
endmodule

bind wbx_interconnect wbx_interconnect_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_stb    (m_stb),
    .m_adr    (m_adr),
    .s_stb    (s_stb),
    .s_ack    (s_ack),
    .m_stall  (m_stall),
    .m_ack    (m_ack),
    .m_err    (m_err),
    .m_dat_r  (m_dat_r),
    .err_addr (err_addr)
);

// File: tb/wbx_interconnect_test.sv
module wbx_interconnect_test;
    localparam int CLK_P = 10;
    localparam int AW = 30;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_cyc = 1'b0, m_stb = 1'b0, m_we = 1'b0;
    logic [AW-1:0] m_adr = '0;
    logic [DW-1:0] m_dat_w = '0;
    logic [3:0]    m_sel = '0;
    logic          m_stall, m_ack, m_err, irq, s_cyc, s_we;
    logic [DW-1:0] m_dat_r, s_dat_w;
    logic [AW-1:0] err_addr, s_adr;
    logic [2:0]    s_stb;
    logic [3:0]    s_sel;
    logic [2:0]    s_stall = '0, s_ack = '0;
    logic [3*DW-1:0] s_dat_r = '0;
    logic          reg_irq = 1'b0, scope_irq = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int seed = 1234;
    bit done = 1'b0;

    logic          e_ack, e_err;
    logic [DW-1:0] e_dat;
    logic [AW-1:0] e_eadr;

    always #(CLK_P/2) clk = ~clk;

    wbx_interconnect uut (
        .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
        .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_stall(m_stall),
        .m_ack(m_ack), .m_err(m_err), .m_dat_r(m_dat_r), .err_addr(err_addr),
        .irq(irq), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_dat_w(s_dat_w), .s_sel(s_sel), .s_stall(s_stall), .s_ack(s_ack),
        .s_dat_r(s_dat_r), .reg_irq(reg_irq), .scope_irq(scope_irq)
    );

    function automatic logic [2:0] ref_sel(input logic [AW-1:0] a);
        logic [2:0] r;
        r[0] = (a[29:4] == 26'h081);
        r[1] = (a[29:4] == 26'h082);
        r[2] = (a[29:12] == 18'h1);
        return r;
    endfunction

    function automatic logic [DW-1:0] ref_dat(input logic [2:0] k, input logic [3*DW-1:0] d);
        if (k[0]) return d[DW-1:0];
        if (k[1]) return d[2*DW-1:DW];
        if (k[2]) return d[3*DW-1:2*DW];
        return '0;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one bus cycle: check registered results of the last cycle, apply new inputs,
    // check combinational results, then predict the registered results
    task automatic cycle(input logic stb, input logic [AW-1:0] a, input logic [2:0] ack,
                         input logic [2:0] stl, input logic [3*DW-1:0] d,
                         input logic ri, input logic si);
        logic [2:0] sel;
        @(negedge clk);
        chk("R8 ack", 64'(m_ack), 64'(e_ack));
        chk("R9 rdata", 64'(m_dat_r), 64'(e_dat));
        chk("R5 err", 64'(m_err), 64'(e_err));
        chk("R6 erraddr", 64'(err_addr), 64'(e_eadr));
        m_stb = stb; m_adr = a; s_ack = ack; s_stall = stl; s_dat_r = d;
        reg_irq = ri; scope_irq = si;
        m_cyc = 1'b1; m_we = $urandom() % 2 == 0; m_dat_w = $urandom(); m_sel = 4'($urandom());
        #1;
        sel = ref_sel(a);
        chk("R1 reg stb", 64'(s_stb[0]), 64'(sel[0] & stb));
        chk("R2 scope stb", 64'(s_stb[1]), 64'(sel[1] & stb));
        chk("R3 mem stb", 64'(s_stb[2]), 64'(sel[2] & stb));
        chk("R4 single", 64'($countones(s_stb) <= 1), 64'd1);
        chk("R7 stall", 64'(m_stall), 64'(|(sel & stl)));
        chk("R10 irq", 64'(irq), 64'(ri | si));
        chk("R11 pass", {s_cyc, s_we, s_sel, s_adr, s_dat_w[27:0]},
                        {m_cyc, m_we, m_sel, m_adr, m_dat_w[27:0]});
        e_eadr = e_err ? a : e_eadr;
        e_err  = stb && (sel == 3'b000);
        e_ack  = |ack;
        e_dat  = ref_dat(ack, d);
    endtask

    function automatic logic [AW-1:0] pick_adr();
        case ($urandom() % 5)
            0: return AW'(32'h810 + $urandom() % 16);
            1: return AW'(32'h820 + $urandom() % 16);
            2: return AW'(32'h1000 + $urandom() % 4096);
            3: return AW'($urandom() % 32);
            default: return AW'($urandom());
        endcase
    endfunction

    initial begin
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 ack", 64'(m_ack), 64'd0);
        chk("R12 err", 64'(m_err), 64'd0);
        chk("R12 rdata", 64'(m_dat_r), 64'd0);
        chk("R12 erraddr", 64'(err_addr), 64'd0);
        rst_n = 1'b1;
        e_ack = 0; e_err = 0; e_dat = '0; e_eadr = '0;
        // decode edges (R1 R2 R3 R4)
        cycle(1, AW'(32'h80F), 0, 3'b111, '0, 0, 0);
        cycle(1, AW'(32'h810), 0, 3'b001, '0, 0, 0);
        cycle(1, AW'(32'h81F), 0, 3'b010, '0, 0, 0);
        cycle(1, AW'(32'h820), 0, 3'b010, '0, 1, 0);
        cycle(1, AW'(32'h82F), 0, 3'b000, '0, 0, 1);
        cycle(1, AW'(32'h830), 0, 3'b111, '0, 0, 0);
        cycle(1, AW'(32'h0FFF), 0, 3'b000, '0, 0, 0);
        cycle(1, AW'(32'h1000), 0, 3'b100, '0, 0, 0);
        cycle(1, AW'(32'h1FFF), 0, 3'b100, '0, 0, 0);
        cycle(1, AW'(32'h2000), 0, 3'b000, '0, 0, 0);
        cycle(1, AW'(32'h0), 0, 3'b000, '0, 0, 0);
        cycle(1, AW'(32'h0), 0, 3'b000, '0, 0, 0);
        cycle(0, AW'(32'h3), 0, 3'b000, '0, 0, 0);
        cycle(0, AW'(32'h5), 0, 3'b000, '0, 0, 0);
        // priority (R9)
        cycle(0, AW'(32'h810), 3'b111, 0, {32'hCCCC0003, 32'hBBBB0002, 32'hAAAA0001}, 0, 0);
        cycle(0, AW'(32'h810), 3'b110, 0, {32'hCCCC0003, 32'hBBBB0002, 32'hAAAA0001}, 0, 0);
        cycle(0, AW'(32'h810), 3'b100, 0, {32'hCCCC0003, 32'hBBBB0002, 32'hAAAA0001}, 0, 0);
        cycle(0, AW'(32'h810), 3'b101, 0, {32'hCCCC0003, 32'hBBBB0002, 32'hAAAA0001}, 0, 0);
        cycle(0, AW'(32'h810), 3'b000, 0, {32'hCCCC0003, 32'hBBBB0002, 32'hAAAA0001}, 0, 0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            cycle($urandom() % 4 != 0, pick_adr(), 3'($urandom()), 3'($urandom()),
                  {$urandom(), $urandom(), $urandom()}, 1'($urandom()), 1'($urandom()));
        end
        cycle(0, '0, 0, 0, '0, 0, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule